// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM. The RAM holds 262,144 words of 16 bits. The host issues one word read or one word write per request over a valid/ready handshake. Each request carries an 18-bit word address, 16 bits of write data and a two-bit byte mask. The controller turns each request into a strobe sequence on the memory pins: a dual-polarity chip select, write enable, output enable, a separate byte enable for each half of the word, and a data bus. The data bus is split into an input vector, an output vector and a drive-enable vector that an external pad ring combines into a tri-state bus.

Every memory timing interval is given as a nanosecond parameter. Each is converted into a whole number of clock cycles, rounded up, with at least one cycle. A read keeps output enable low long enough to cover both address access and output-enable access. The word is then captured into a register and returned with a one-cycle valid pulse. A write keeps write enable low long enough to cover the pulse width, address-to-end-of-write and data setup. Output enable stays high and the drivers are enabled for exactly that window. After every read, the controller waits out the memory's output float time before it can drive the bus again. After every write, it leaves a recovery gap so the full write cycle time is met.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `mem_ce1_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are 1, `mem_ce2` is 0, `mem_dq_oe` is all zeros and `rd_valid` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 1 only while the controller is idle. With the default parameters (10 ns clock), `req_ready` stays 0 for 10 cycles after a read is taken and for 7 cycles after a write is taken.
- R3: The memory is selected (`mem_ce1_n` = 0 and `mem_ce2` = 1) exactly while write enable or output enable is low, and is otherwise in standby. While either strobe is low, `mem_addr` equals the request address.
- R4: A write drives `mem_we_n` low for exactly ceil(max(50, 60, 35) ns / period) consecutive cycles (6 at defaults). During those cycles `mem_oe_n` is 1, `mem_dq_oe` is all ones and `mem_dq_out` equals the request write data. `mem_dq_oe` is never non-zero while `mem_we_n` is 1.
- R5: A read drives `mem_oe_n` low for exactly ceil(max(70, 35) ns / period) consecutive cycles (7 at defaults). During those cycles `mem_we_n` is 1 and `mem_dq_oe` is all zeros.
- R6: Request mask bit 1 selects data bits 15:8 through `mem_ub_n`, and mask bit 0 selects bits 7:0 through `mem_lb_n`. A byte enable is low only while the memory is selected and its mask bit is 1, so a byte whose mask bit is 0 keeps its old contents in memory.
- R7: Read data is registered from `mem_dq_in` on the last read-strobe cycle. `rd_valid` is high for one cycle, namely the 8th cycle after the accepting edge at defaults (read-strobe count + 1 edges). Bytes whose mask bit is 0 read as zero.
- R8: After `mem_oe_n` returns high, `mem_dq_oe` stays all zeros for at least ceil(25 ns / period) cycles (3 at defaults), so the controller never drives the bus while the memory may still be driving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| rd_valid | output | 1 | One-cycle pulse, read data present |
| rd_data | output | 16 | Registered read data |
| mem_addr | output | 18 | Memory address |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_oe | output | 16 | Per-bit data drive enable |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_in | input | 16 | Data returned from memory |

## Verification
At the default 10 ns clock, the strobes change one edge after the accepting edge. The read strobe lasts 7 cycles and the read word comes out with `rd_valid` in the 8th cycle after acceptance. `req_ready` returns after 10 cycles for a read and 7 cycles for a write. The driver applies each request at a falling edge and then samples the memory pins and `req_ready` at every following falling edge until ready returns. At each sample it counts strobe cycles and records the sample index of the valid pulse, so every count is compared with these exact figures. A scoreboard queue is filled when each read is issued and drained at falling edges where `rd_valid` is high. A behavioural memory model commits writes at rising edges and updates its read bus at falling edges, so no check depends on the order of processes at an edge.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    parameter int ADDR_W = 18;
    parameter int DATA_W = 16;
    parameter int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_WREC
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
    } host_req_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Whole clock cycles covering a duration, never less than one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC   = 7,
    parameter int TURN_CYC = 3,
    parameter int WP_CYC   = 6,
    parameter int REC_CYC  = 1,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic              tmr_zero,
    output seq_state_e        state,
    output host_req_t         cur,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              capture,
    output logic              rd_valid
);
    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);

    seq_state_e nxt;

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (state)
            ST_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                tmr_val  = req_write ? WP_LD : RD_LD;
                nxt      = req_write ? ST_WRITE : ST_READ;
            end
            ST_READ: if (tmr_zero) begin
                capture  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TURN_LD;
                nxt      = ST_TURN;
            end
            ST_TURN: if (tmr_zero) nxt = ST_IDLE;
            ST_WRITE: if (tmr_zero) begin
                tmr_load = 1'b1;
                tmr_val  = REC_LD;
                nxt      = ST_WREC;
            end
            ST_WREC: if (tmr_zero) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur      <= '0;
            rd_valid <= 1'b0;
        end else begin
            state    <= nxt;
            rd_valid <= capture;
            if (state == ST_IDLE && req_valid) begin
                cur.write <= req_write;
                cur.addr  <= req_addr;
                cur.wdata <= req_wdata;
                cur.mask  <= req_mask;
            end
        end
    end
endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              capture,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic [LANES-1:0]  be_n,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] lane_q;

        assign be_n[i] = !(strobe && mask[i]);

        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= 8'h00;
            else if (capture)
                lane_q <= mask[i] ? dq_in[i*8 +: 8] : 8'h00;
        end

        assign rd_data[i*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_OE_NS       = 35,
    parameter int T_OHZ_NS      = 25,
    parameter int T_WC_NS       = 70,
    parameter int T_WP_NS       = 50,
    parameter int T_AW_NS       = 60,
    parameter int T_DW_NS       = 35
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_oe,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_CYC   = ns_to_cyc(imax(T_AA_NS, T_OE_NS), CLK_PERIOD_NS);
    localparam int TURN_CYC = imax(ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_RC_NS, CLK_PERIOD_NS) - RD_CYC);
    localparam int WP_CYC   = ns_to_cyc(imax(T_WP_NS, imax(T_AW_NS, T_DW_NS)), CLK_PERIOD_NS);
    localparam int REC_CYC  = imax(1, ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - WP_CYC);
    localparam int MAX_CYC  = imax(imax(RD_CYC, TURN_CYC), imax(WP_CYC, REC_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    seq_state_e       state;
    host_req_t        cur;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             capture;
    logic             strobe_rd;
    logic             strobe_wr;
    logic [LANES-1:0] be_n;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_ctl_seq #(
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .WP_CYC   (WP_CYC),
        .REC_CYC  (REC_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .tmr_zero  (tmr_zero),
        .state     (state),
        .cur       (cur),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .capture   (capture),
        .rd_valid  (rd_valid)
    );

    assign strobe_rd = (state == ST_READ);
    assign strobe_wr = (state == ST_WRITE);

    sram_ctl_lanes u_lanes (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe_rd || strobe_wr),
        .capture (capture),
        .mask    (cur.mask),
        .dq_in   (mem_dq_in),
        .be_n    (be_n),
        .rd_data (rd_data)
    );

    assign req_ready  = (state == ST_IDLE);
    assign mem_addr   = cur.addr;
    assign mem_ce1_n  = !(strobe_rd || strobe_wr);
    assign mem_ce2    = strobe_rd || strobe_wr;
    assign mem_we_n   = !strobe_wr;
    assign mem_oe_n   = !strobe_rd;
    assign mem_ub_n   = be_n[1];
    assign mem_lb_n   = be_n[0];
    assign mem_dq_oe  = {DATA_W{strobe_wr}};
    assign mem_dq_out = cur.wdata;
endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_OHZ_NS      = 25,
    parameter int T_WP_NS       = 50,
    parameter int T_AW_NS       = 60,
    parameter int T_DW_NS       = 35
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic [DATA_W-1:0] mem_dq_oe,
    input logic [DATA_W-1:0] mem_dq_out
);
    localparam int WP_CYC  = ns_to_cyc(imax(T_WP_NS, imax(T_AW_NS, T_DW_NS)), CLK_PERIOD_NS);
    localparam int OHZ_CYC = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);

    int we_run;
    int oe_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run  <= 0;
            oe_high <= OHZ_CYC;
        end else begin
            we_run  <= mem_we_n ? 0 : we_run + 1;
            if (!mem_oe_n)
                oe_high <= 0;
            else if (oe_high < OHZ_CYC)
                oe_high <= oe_high + 1;
        end
    end

    // R3
    strobe_selects_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_oe_n) |-> (!mem_ce1_n && mem_ce2));

    // R2
    busy_while_selected_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce1_n) |-> !req_ready);

    // R4
    no_oe_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R4
    drive_only_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe != '0) |-> !mem_we_n);

    // R4
    write_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_run == WP_CYC));

    // R4
    write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R6
    lanes_idle_chk: assert property (@(posedge clk) disable iff (rst)
        mem_ce1_n |-> (mem_ub_n && mem_lb_n));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe != '0) |-> (oe_high >= OHZ_CYC));
endmodule

bind sram_access_ctrl sram_ctl_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_ce1_n  (mem_ce1_n),
    .mem_ce2    (mem_ce2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_ub_n   (mem_ub_n),
    .mem_lb_n   (mem_lb_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_out (mem_dq_out)
);

// File: tb/sram_access_ctrl_test.sv
module sram_access_ctrl_test;
    localparam int RD_N   = 7;
    localparam int WP_N   = 6;
    localparam int RBUSY  = 10;
    localparam int WBUSY  = 7;
    localparam int TURN_N = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dq_oe, mem_dq_out;
    logic [15:0] mem_dq_in = 16'hBEEF;

    int n_checks = 0;
    int n_fail   = 0;
    int oe_hi_run = 0;

    logic [15:0] ext_mem [logic [17:0]];
    logic [15:0] ref_mem [logic [17:0]];
    logic [15:0] exp_q [$];

    always #5 clk = ~clk;

    sram_access_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
        .mem_lb_n(mem_lb_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // External memory model: writes commit at rising edges, read bus updates at falling edges.
    always @(posedge clk) begin
        if (!mem_ce1_n && mem_ce2 && !mem_we_n) begin
            logic [15:0] w;
            w = ext_mem.exists(mem_addr) ? ext_mem[mem_addr] : 16'h0000;
            if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
            if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
            ext_mem[mem_addr] = w;
        end
        oe_hi_run <= mem_oe_n ? oe_hi_run + 1 : 0;
    end

    always @(negedge clk) begin
        if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) begin
            logic [15:0] r;
            r = ext_mem.exists(mem_addr) ? ext_mem[mem_addr] : 16'h0000;
            mem_dq_in <= {mem_ub_n ? 8'hEE : r[15:8], mem_lb_n ? 8'hEE : r[7:0]};
        end else begin
            mem_dq_in <= 16'hBEEF;
        end
    end

    // Scoreboard monitor (R7)
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0)
                check("R7 unexpected rd_valid", 32'd1, 32'd0);
            else
                check("R7 rd_data", {16'h0, rd_data}, {16'h0, exp_q.pop_front()});
        end
    end

    task automatic do_req(input logic wr, input logic [17:0] a,
                          input logic [15:0] d, input logic [1:0] m);
        int n = 0, nwe = 0, noe = 0, nce = 0, vat = -1, bad = 0, lane_bad = 0, gap = -1;
        logic [15:0] cur;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        cur = ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
        if (wr) begin
            if (m[1]) cur[15:8] = d[15:8];
            if (m[0]) cur[7:0]  = d[7:0];
            ref_mem[a] = cur;
        end else begin
            exp_q.push_back({m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00});
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && n < 50) begin
            if (!mem_we_n) nwe++;
            if (!mem_oe_n) noe++;
            if (!mem_ce1_n && mem_ce2) nce++;
            if (rd_valid) vat = n;
            if ((!mem_we_n || !mem_oe_n) && mem_addr != a) bad++;
            if (!mem_we_n && (mem_dq_oe != 16'hFFFF || mem_dq_out != d)) bad++;
            if (mem_we_n && mem_dq_oe != 16'h0000) bad++;
            if (mem_dq_oe != 16'h0000 && gap < 0) gap = oe_hi_run;
            if ((!mem_ce1_n && mem_ce2) ? ({!mem_ub_n, !mem_lb_n} != m)
                                         : (!mem_ub_n || !mem_lb_n)) lane_bad++;
            n++;
            @(negedge clk);
        end
        check("R2 busy cycles", n, wr ? WBUSY : RBUSY);
        check("R3 select matches strobe", nce, nwe + noe);
        check("R3 R4 addr/data/drive", bad, 0);
        check("R6 byte enables", lane_bad, 0);
        if (wr) begin
            check("R4 we_n low cycles", nwe, WP_N);
            check("R4 oe_n held high", noe, 0);
            check("R8 turnaround", (gap >= TURN_N) ? 1 : 0, 1);
        end else begin
            check("R5 oe_n low cycles", noe, RD_N);
            check("R5 we_n held high", nwe, 0);
            check("R7 rd_valid position", vat, RD_N);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 reset outputs",
              {req_ready, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n,
               (mem_dq_oe == 16'h0), rd_valid}, 9'b110111110);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset",
              {req_ready, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, (mem_dq_oe == 16'h0), rd_valid},
              7'b1101110);

        do_req(1'b1, 18'h00010, 16'hA5C3, 2'b11);
        do_req(1'b0, 18'h00010, 16'h0000, 2'b11);
        do_req(1'b1, 18'h00000, 16'h1234, 2'b11);
        do_req(1'b1, 18'h3FFFF, 16'hBEAD, 2'b11);
        do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
        do_req(1'b0, 18'h00000, 16'h0000, 2'b11);
        // R6 partial writes keep the other byte
        do_req(1'b1, 18'h00100, 16'hFFFF, 2'b11);
        do_req(1'b1, 18'h00100, 16'h00AA, 2'b01);
        do_req(1'b1, 18'h00100, 16'h5500, 2'b10);
        do_req(1'b0, 18'h00100, 16'h0000, 2'b11);
        // R7 masked reads return zero in the unselected byte
        do_req(1'b0, 18'h00100, 16'h0000, 2'b01);
        do_req(1'b0, 18'h00100, 16'h0000, 2'b10);
        do_req(1'b0, 18'h2A5A5, 16'h0000, 2'b11);
        // R8 read directly followed by write, then write after write
        do_req(1'b1, 18'h00100, 16'hC0DE, 2'b11);
        do_req(1'b1, 18'h00101, 16'h7E57, 2'b11);
        do_req(1'b0, 18'h00101, 16'h0000, 2'b11);
        do_req(1'b0, 18'h00100, 16'h0000, 2'b11);

        repeat (12) @(negedge clk);
        check("R7 scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule